// File: doc/BRIEF.md
# Integer Stack Execution Core

This block runs programs for a simple stack machine, restricted to the integer, Boolean, address-arithmetic and branch instructions. It fetches 30-bit instruction words from a code memory through a read port with a same-cycle answer. It keeps the operand stack in a data memory reached through one read/write port, which also answers a read in the same cycle. The stack grows upward from a base address set by a parameter. A push writes at the stack pointer and then advances it, so the top element always sits at the pointer minus one.

Each instruction takes a few cycles. The core fetches the word, reads the top of the stack, reads the element beneath it or a memory word when the instruction needs one, and then writes the result back. Branch targets are plain instruction indices taken from the Q field. When the core meets a stop word it raises `halted`. A fault raises both `error` and `halted`: an out-of-range bounds check, a division by zero, an unsupported opcode or an unsupported compare key. The core advances only while `run` is high.

Top module: `stk_core`

## Requirements
- R1: Instruction words are split as opcode in bits 29:24, P in bits 23:20 and Q in bits 19:0. Load-constant (opcode 51) pushes Q sign-extended to the data width. Stop (opcode 58) raises halted and leaves error low.
- R2: Integer add (28) pushes next+top. Absolute value (40) replaces the top with its magnitude. Boolean and (43) and inclusive or (44) push the bitwise and/or of the next and top elements. Binary operations pop two elements and push one.
- R3: Integer divide (53) pushes next/top, truncated toward zero. A top of zero raises error and halted and writes nothing.
- R4: Equal (17), greater-or-equal (19) and greater-than (20) pop two elements and push 1 or 0, with the deeper element on the left of the relation. The key in P selects the comparison: 0 is address (unsigned), 1 is integer (signed), 2 is Boolean.
- R5: A compare whose key is not 0, 1 or 2 raises error and halted without writing a result.
- R6: Increment (10) and decrement (57) add Q to the top address or subtract Q from it. Indexed fetch (9) replaces the top address with the data word stored at address+Q.
- R7: Indexed address (16) pops an index i and then a base a, and pushes a + i*Q.
- R8: Unconditional jump (23) loads the program counter with Q. False jump (24) pops one element and loads the program counter with Q only when that element is 0.
- R9: Bounds check (26) compares the top as a signed value against a lower bound at data address Q and an upper bound at Q+1, both inclusive. In range, it leaves the stack unchanged. Out of range, it raises error and halted.
- R10: Any other opcode, including standard-procedure call (15), raises error and halted and writes no memory.
- R11: Halted and error stay set until reset, error never appears without halted, and no data write happens while halted.
- R12: After reset the code address is 0 and halted and error are low. While run is low, the code address holds and no data write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Advance enable |
| code_addr | output | PCW | Instruction index being fetched |
| code_rdata | input | 30 | Instruction word at code_addr |
| dmem_addr | output | DAW | Data memory address |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_wdata | output | DW | Data memory write value |
| dmem_rdata | input | DW | Data memory read value at dmem_addr |
| halted | output | 1 | Core has stopped |
| error | output | 1 | Core stopped on a fault |

## Verification
Every data write is compared, in order, with a predicted sequence of address and value pairs. A missing, extra or misplaced write therefore shows up at once.

The arithmetic program mixes positive and negative operands. This separates signed from unsigned compares under the address and integer keys, exposes a division that floors instead of truncating, and confirms that the deeper element is the left operand.

The addressing program walks increment, decrement, indexed fetch and indexed address into a shared target word. It takes a false jump both ways and hits both bounds of a range check exactly, so off-by-one bound handling and inverted branch senses are caught. Short fault programs prove that each fault stops the core before the following instruction writes anything. An idle period with run low proves the hold.

// File: rtl/stk_pkg.sv
package stk_pkg;
   localparam int INSTR_W = 30;
   localparam int OPC_W   = 6;
   localparam int PRM_W   = 4;
   localparam int Q_W     = 20;

   localparam logic [OPC_W-1:0] OP_IND = 6'd9;
   localparam logic [OPC_W-1:0] OP_INC = 6'd10;
   localparam logic [OPC_W-1:0] OP_IXA = 6'd16;
   localparam logic [OPC_W-1:0] OP_EQU = 6'd17;
   localparam logic [OPC_W-1:0] OP_GEQ = 6'd19;
   localparam logic [OPC_W-1:0] OP_GRT = 6'd20;
   localparam logic [OPC_W-1:0] OP_UJP = 6'd23;
   localparam logic [OPC_W-1:0] OP_FJP = 6'd24;
   localparam logic [OPC_W-1:0] OP_CHK = 6'd26;
   localparam logic [OPC_W-1:0] OP_ADI = 6'd28;
   localparam logic [OPC_W-1:0] OP_ABI = 6'd40;
   localparam logic [OPC_W-1:0] OP_AND = 6'd43;
   localparam logic [OPC_W-1:0] OP_IOR = 6'd44;
   localparam logic [OPC_W-1:0] OP_LDC = 6'd51;
   localparam logic [OPC_W-1:0] OP_DVI = 6'd53;
   localparam logic [OPC_W-1:0] OP_DEC = 6'd57;
   localparam logic [OPC_W-1:0] OP_STP = 6'd58;

   localparam logic [PRM_W-1:0] KEY_ADDR = 4'd0;
   localparam logic [PRM_W-1:0] KEY_INT  = 4'd1;
   localparam logic [PRM_W-1:0] KEY_BOOL = 4'd2;

   typedef enum logic [2:0] {
      ST_FETCH, ST_TOP, ST_NEXT, ST_MEM, ST_MEM2, ST_WRITE, ST_HALT
   } state_t;

   typedef enum logic [3:0] {
      K_PUSH, K_STOP, K_UJP, K_FJP, K_UNARY, K_BINARY, K_IND, K_CHK, K_BAD
   } kind_t;
endpackage

// File: rtl/stk_decode.sv
module stk_decode
   import stk_pkg::*;
#(
   parameter bit HAS_DIV = 1'b1
) (
   input  logic [OPC_W-1:0] opc,
   input  logic [PRM_W-1:0] prm,
   output kind_t            kind
);
   logic key_ok;
   assign key_ok = (prm == KEY_ADDR) || (prm == KEY_INT) || (prm == KEY_BOOL);

   always_comb begin
      unique case (opc)
         OP_LDC:                         kind = K_PUSH;
         OP_STP:                         kind = K_STOP;
         OP_UJP:                         kind = K_UJP;
         OP_FJP:                         kind = K_FJP;
         OP_INC, OP_DEC, OP_ABI:         kind = K_UNARY;
         OP_ADI, OP_AND, OP_IOR, OP_IXA: kind = K_BINARY;
         OP_DVI:                         kind = HAS_DIV ? K_BINARY : K_BAD;
         OP_EQU, OP_GEQ, OP_GRT:         kind = key_ok ? K_BINARY : K_BAD;
         OP_IND:                         kind = K_IND;
         OP_CHK:                         kind = K_CHK;
         default:                        kind = K_BAD;
      endcase
   end
endmodule

// File: rtl/stk_alu.sv
module stk_alu
   import stk_pkg::*;
#(
   parameter int DW      = 32,
   parameter bit HAS_DIV = 1'b1
) (
   input  logic [OPC_W-1:0] opc,
   input  logic [PRM_W-1:0] prm,
   input  logic [Q_W-1:0]   q,
   input  logic [DW-1:0]    a,     // stack top
   input  logic [DW-1:0]    b,     // element beneath the top
   output logic [DW-1:0]    res,
   output logic             div_zero
);
   localparam int EXT_W = DW - Q_W;

   logic [DW-1:0] qz;
   logic [DW-1:0] quo;
   logic          eq, ge, gt;

   assign qz = {{EXT_W{1'b0}}, q};
   assign eq = (b == a);
   assign ge = (prm == KEY_INT) ? ($signed(b) >= $signed(a)) : (b >= a);
   assign gt = (prm == KEY_INT) ? ($signed(b) >  $signed(a)) : (b >  a);
   assign div_zero = (opc == OP_DVI) && (a == '0);

   generate
      if (HAS_DIV) begin : g_div
         assign quo = (a == '0) ? '0 : DW'($signed(b) / $signed(a));
      end else begin : g_nodiv
         assign quo = '0;
      end
   endgenerate

   always_comb begin
      unique case (opc)
         OP_INC:  res = a + qz;
         OP_DEC:  res = a - qz;
         OP_ABI:  res = a[DW-1] ? (~a + 1'b1) : a;
         OP_ADI:  res = b + a;
         OP_AND:  res = b & a;
         OP_IOR:  res = b | a;
         OP_IXA:  res = b + DW'(a * qz);
         OP_DVI:  res = quo;
         OP_EQU:  res = {{(DW-1){1'b0}}, eq};
         OP_GEQ:  res = {{(DW-1){1'b0}}, ge};
         OP_GRT:  res = {{(DW-1){1'b0}}, gt};
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/stk_core.sv
module stk_core
   import stk_pkg::*;
#(
   parameter int DW         = 32,
   parameter int PCW        = 10,
   parameter int DAW        = 12,
   parameter int STACK_BASE = 100,
   parameter bit HAS_DIV    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   output logic [PCW-1:0]     code_addr,
   input  logic [INSTR_W-1:0] code_rdata,
   output logic [DAW-1:0]     dmem_addr,
   output logic               dmem_we,
   output logic [DW-1:0]      dmem_wdata,
   input  logic [DW-1:0]      dmem_rdata,
   output logic               halted,
   output logic               error
);
   localparam logic [DAW-1:0] ONE   = DAW'(1);
   localparam logic [DAW-1:0] TWO   = DAW'(2);
   localparam logic [DAW-1:0] SP_RS = DAW'(STACK_BASE);
   localparam int             EXT_W = DW - Q_W;

   generate
      if (DW < Q_W + 1) begin : g_bad_dw
         $error("stk_core: DW must exceed the Q field width");
      end
      if (PCW > Q_W || DAW > Q_W) begin : g_bad_aw
         $error("stk_core: address widths must fit in the Q field");
      end
      if (STACK_BASE >= (1 << DAW)) begin : g_bad_base
         $error("stk_core: STACK_BASE outside data space");
      end
   endgenerate

   state_t              state;
   kind_t               kind_f, kind_q;
   logic [INSTR_W-1:0]  ir;
   logic [PCW-1:0]      pc;
   logic [DAW-1:0]      sp, maddr, waddr;
   logic [DW-1:0]       opa, lo, res_q;
   logic                halt_q, err_q;

   logic [OPC_W-1:0]    ir_opc;
   logic [PRM_W-1:0]    ir_prm;
   logic [Q_W-1:0]      ir_q, f_q;
   logic [DW-1:0]       alu_a, alu_res;
   logic                alu_dz;

   assign ir_opc = ir[INSTR_W-1 -: OPC_W];
   assign ir_prm = ir[Q_W +: PRM_W];
   assign ir_q   = ir[Q_W-1:0];
   assign f_q    = code_rdata[Q_W-1:0];

   stk_decode #(.HAS_DIV(HAS_DIV)) u_dec (
      .opc  (code_rdata[INSTR_W-1 -: OPC_W]),
      .prm  (code_rdata[Q_W +: PRM_W]),
      .kind (kind_f)
   );

   assign alu_a = (state == ST_TOP) ? dmem_rdata : opa;

   stk_alu #(.DW(DW), .HAS_DIV(HAS_DIV)) u_alu (
      .opc      (ir_opc),
      .prm      (ir_prm),
      .q        (ir_q),
      .a        (alu_a),
      .b        (dmem_rdata),
      .res      (alu_res),
      .div_zero (alu_dz)
   );

   always_comb begin
      unique case (state)
         ST_TOP:          dmem_addr = sp - ONE;
         ST_NEXT:         dmem_addr = sp - TWO;
         ST_MEM, ST_MEM2: dmem_addr = maddr;
         ST_WRITE:        dmem_addr = waddr;
         default:         dmem_addr = sp;
      endcase
   end

   assign code_addr  = pc;
   assign dmem_we    = (state == ST_WRITE) && run;
   assign dmem_wdata = res_q;
   assign halted     = halt_q;
   assign error      = err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_FETCH;
         kind_q <= K_BAD;
         ir     <= '0;
         pc     <= '0;
         sp     <= SP_RS;
         maddr  <= '0;
         waddr  <= '0;
         opa    <= '0;
         lo     <= '0;
         res_q  <= '0;
         halt_q <= 1'b0;
         err_q  <= 1'b0;
      end else if (run) begin
         unique case (state)
            ST_FETCH: begin
               ir     <= code_rdata;
               kind_q <= kind_f;
               pc     <= pc + 1'b1;
               unique case (kind_f)
                  K_PUSH: begin
                     res_q <= {{EXT_W{f_q[Q_W-1]}}, f_q};
                     waddr <= sp;
                     sp    <= sp + ONE;
                     state <= ST_WRITE;
                  end
                  K_STOP: begin
                     halt_q <= 1'b1;
                     state  <= ST_HALT;
                  end
                  K_UJP: pc <= f_q[PCW-1:0];
                  K_BAD: begin
                     halt_q <= 1'b1;
                     err_q  <= 1'b1;
                     state  <= ST_HALT;
                  end
                  default: state <= ST_TOP;
               endcase
            end
            ST_TOP: begin
               opa <= dmem_rdata;
               unique case (kind_q)
                  K_UNARY: begin
                     res_q <= alu_res;
                     waddr <= sp - ONE;
                     state <= ST_WRITE;
                  end
                  K_FJP: begin
                     sp <= sp - ONE;
                     if (dmem_rdata == '0) pc <= ir_q[PCW-1:0];
                     state <= ST_FETCH;
                  end
                  K_IND: begin
                     maddr <= dmem_rdata[DAW-1:0] + ir_q[DAW-1:0];
                     state <= ST_MEM;
                  end
                  K_CHK: begin
                     maddr <= ir_q[DAW-1:0];
                     state <= ST_MEM;
                  end
                  default: state <= ST_NEXT;
               endcase
            end
            ST_NEXT: begin
               if (alu_dz) begin
                  halt_q <= 1'b1;
                  err_q  <= 1'b1;
                  state  <= ST_HALT;
               end else begin
                  res_q <= alu_res;
                  waddr <= sp - TWO;
                  sp    <= sp - ONE;
                  state <= ST_WRITE;
               end
            end
            ST_MEM: begin
               if (kind_q == K_IND) begin
                  res_q <= dmem_rdata;
                  waddr <= sp - ONE;
                  state <= ST_WRITE;
               end else begin
                  lo    <= dmem_rdata;
                  maddr <= maddr + ONE;
                  state <= ST_MEM2;
               end
            end
            ST_MEM2: begin
               if ($signed(opa) < $signed(lo) || $signed(opa) > $signed(dmem_rdata)) begin
                  halt_q <= 1'b1;
                  err_q  <= 1'b1;
                  state  <= ST_HALT;
               end else begin
                  state <= ST_FETCH;
               end
            end
            ST_WRITE: state <= ST_FETCH;
            default:  state <= ST_HALT;
         endcase
      end
   end
endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk #(
   parameter int DW  = 32,
   parameter int PCW = 10,
   parameter int DAW = 12
) (
   input logic           clk,
   input logic           rst_n,
   input logic           run,
   input logic [PCW-1:0] code_addr,
   input logic           dmem_we,
   input logic           halted,
   input logic           error
);
   // R11: a stopped core stays stopped
   a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);
   // R11: fault flag stays set
   a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> error);
   // R11: a fault always comes with halted
   a_r11_err_halted: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> halted);
   // R11: no data write after stopping
   a_r11_no_write_halted: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !dmem_we);
   // R11: fetch address frozen once stopped
   a_r11_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(code_addr));
   // R12: run low holds the fetch address
   a_r12_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(code_addr));
   // R12: run low blocks data writes
   a_r12_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !dmem_we);
endmodule

bind stk_core stk_core_chk #(.DW(DW), .PCW(PCW), .DAW(DAW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (run),
   .code_addr (code_addr),
   .dmem_we   (dmem_we),
   .halted    (halted),
   .error     (error)
);

// File: tb/stk_core_tb.sv
module stk_core_tb;
   localparam int DW = 32, PCW = 10, DAW = 12, BASE = 100;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            run = 1'b0;
   logic [PCW-1:0]  code_addr;
   logic [29:0]     code_rdata;
   logic [DAW-1:0]  dmem_addr;
   logic            dmem_we;
   logic [DW-1:0]   dmem_wdata, dmem_rdata;
   logic            halted, error;

   logic [29:0]     cmem [64];
   logic [DW-1:0]   dmem [256];

   int n_run = 0, n_fail = 0, cyc = 0;
   logic [DAW+DW-1:0] exp_q [$];
   string             tag_q [$];

   always #5 clk = ~clk;

   stk_core #(.DW(DW), .PCW(PCW), .DAW(DAW), .STACK_BASE(BASE)) u_dut (
      .clk(clk), .rst_n(rst_n), .run(run),
      .code_addr(code_addr), .code_rdata(code_rdata),
      .dmem_addr(dmem_addr), .dmem_we(dmem_we),
      .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
      .halted(halted), .error(error));

   assign code_rdata = cmem[code_addr[5:0]];
   assign dmem_rdata = dmem[dmem_addr[7:0]];

   always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: every write must match the next predicted item
   always @(negedge clk) begin
      if (rst_n && dmem_we) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "unexpected write R10/R11/R12", {dmem_addr, dmem_wdata}, 0);
         end else begin
            logic [DAW+DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({dmem_addr, dmem_wdata} == e, t, {dmem_addr, dmem_wdata}, e);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         check(1'b0, "watchdog", cyc, 150000);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   function automatic logic [29:0] mk(input int op, input int p, input int q);
      logic [5:0]  o = op[5:0];
      logic [3:0]  pp = p[3:0];
      logic [19:0] qq = q[19:0];
      return {o, pp, qq};
   endfunction

   task automatic expw(input int a, input int v, input string tag);
      logic [DAW-1:0] aa = a[DAW-1:0];
      logic [DW-1:0]  vv = v;
      exp_q.push_back({aa, vv});
      tag_q.push_back(tag);
   endtask

   task automatic clear_all();
      for (int i = 0; i < 64; i++) cmem[i] = mk(58, 0, 0);
      for (int i = 0; i < 256; i++) dmem[i] = '0;
      exp_q.delete();
      tag_q.delete();
   endtask

   task automatic start();
      @(negedge clk); rst_n = 1'b0; run = 1'b0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1; run = 1'b1;
   endtask

   task automatic finish_prog(input bit exp_err, input string tag);
      int n = 0;
      while (!halted && n < 2000) begin @(negedge clk); n++; end
      repeat (3) @(negedge clk);
      check(halted == 1'b1, {tag, " halted R11"}, halted, 1);
      check(error == exp_err, {tag, " error flag"}, error, exp_err);
      check(exp_q.size() == 0, {tag, " missing writes"}, exp_q.size(), 0);
      run = 1'b0;
   endtask

   initial begin
      // ---- reset state and run-low hold (R12)
      clear_all();
      cmem[0] = mk(51, 0, 1);
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      check(code_addr == 0, "R12 reset code_addr", code_addr, 0);
      check(halted == 1'b0, "R12 reset halted", halted, 0);
      check(error == 1'b0, "R12 reset error", error, 0);
      repeat (10) @(negedge clk);
      check(code_addr == 0, "R12 run low holds", code_addr, 0);

      // ---- program 1: arithmetic and compares
      clear_all();
      cmem[0]  = mk(51,0,7);    expw(100, 7,  "R1 push");
      cmem[1]  = mk(51,0,-3);   expw(101, -3, "R1 sign extend");
      cmem[2]  = mk(28,0,0);    expw(100, 4,  "R2 add");
      cmem[3]  = mk(51,0,-9);   expw(101, -9, "R1 push neg");
      cmem[4]  = mk(40,0,0);    expw(101, 9,  "R2 abs");
      cmem[5]  = mk(20,1,0);    expw(100, 0,  "R4 grt int");
      cmem[6]  = mk(51,0,-7);   expw(101, -7, "R1 push");
      cmem[7]  = mk(51,0,2);    expw(102, 2,  "R1 push");
      cmem[8]  = mk(53,0,0);    expw(101, -3, "R3 div truncates");
      cmem[9]  = mk(51,0,-3);   expw(102, -3, "R1 push");
      cmem[10] = mk(17,1,0);    expw(101, 1,  "R4 equ");
      cmem[11] = mk(43,0,0);    expw(100, 0,  "R2 and");
      cmem[12] = mk(51,0,1);    expw(101, 1,  "R1 push");
      cmem[13] = mk(44,0,0);    expw(100, 1,  "R2 ior");
      cmem[14] = mk(51,0,5);    expw(101, 5,  "R1 push");
      cmem[15] = mk(51,0,-1);   expw(102, -1, "R1 push");
      cmem[16] = mk(19,0,0);    expw(101, 0,  "R4 geq address unsigned");
      cmem[17] = mk(51,0,5);    expw(102, 5,  "R1 push");
      cmem[18] = mk(51,0,-1);   expw(103, -1, "R1 push");
      cmem[19] = mk(19,1,0);    expw(102, 1,  "R4 geq int signed");
      cmem[20] = mk(51,0,6);    expw(103, 6,  "R1 push");
      cmem[21] = mk(51,0,6);    expw(104, 6,  "R1 push");
      cmem[22] = mk(20,2,0);    expw(103, 0,  "R4 grt bool equal");
      cmem[23] = mk(58,0,0);
      cmem[24] = mk(51,0,1);    // must not run after stop
      start();
      finish_prog(1'b0, "R1 stop");

      // ---- program 2: addressing, jumps, bounds
      clear_all();
      dmem[10] = 3; dmem[11] = 8; dmem[50] = 77; dmem[52] = 123;
      cmem[0]  = mk(51,0,48);   expw(100, 48,  "R1 push");
      cmem[1]  = mk(10,0,4);    expw(100, 52,  "R6 inc");
      cmem[2]  = mk(57,0,2);    expw(100, 50,  "R6 dec");
      cmem[3]  = mk(9,0,2);     expw(100, 123, "R6 indexed fetch");
      cmem[4]  = mk(51,0,40);   expw(101, 40,  "R1 push");
      cmem[5]  = mk(51,0,3);    expw(102, 3,   "R1 push");
      cmem[6]  = mk(16,0,4);    expw(101, 52,  "R7 indexed address");
      cmem[7]  = mk(9,0,0);     expw(101, 123, "R6 fetch");
      cmem[8]  = mk(17,1,0);    expw(100, 1,   "R4 equ");
      cmem[9]  = mk(24,0,30);   // true: fall through
      cmem[10] = mk(51,0,0);    expw(100, 0,   "R8 fjp not taken");
      cmem[11] = mk(24,0,13);   // false: jump
      cmem[12] = mk(51,0,99);
      cmem[13] = mk(51,0,5);    expw(100, 5,   "R8 fjp taken");
      cmem[14] = mk(26,0,10);
      cmem[15] = mk(23,0,17);
      cmem[16] = mk(51,0,98);
      cmem[17] = mk(51,0,8);    expw(101, 8,   "R8 ujp target");
      cmem[18] = mk(26,0,10);
      cmem[19] = mk(51,0,3);    expw(102, 3,   "R9 upper bound passes");
      cmem[20] = mk(26,0,10);
      cmem[21] = mk(51,0,-2);   expw(103, -2,  "R9 lower bound passes");
      cmem[22] = mk(58,0,0);
      start();
      finish_prog(1'b0, "R9 in range");

      // ---- fault programs
      clear_all();
      dmem[10] = 3; dmem[11] = 8;
      cmem[0] = mk(51,0,9);     expw(100, 9, "R1 push");
      cmem[1] = mk(26,0,10);
      cmem[2] = mk(51,0,1);
      start();
      finish_prog(1'b1, "R9 above range");

      clear_all();
      dmem[10] = 3; dmem[11] = 8;
      cmem[0] = mk(51,0,2);     expw(100, 2, "R1 push");
      cmem[1] = mk(26,0,10);
      cmem[2] = mk(51,0,1);
      start();
      finish_prog(1'b1, "R9 below range");

      clear_all();
      cmem[0] = mk(51,0,5);     expw(100, 5, "R1 push");
      cmem[1] = mk(51,0,0);     expw(101, 0, "R1 push");
      cmem[2] = mk(53,0,0);
      cmem[3] = mk(51,0,1);
      start();
      finish_prog(1'b1, "R3 zero divisor");

      clear_all();
      cmem[0] = mk(15,0,3);
      cmem[1] = mk(51,0,1);
      start();
      finish_prog(1'b1, "R10 std call");

      clear_all();
      cmem[0] = mk(51,0,1);     expw(100, 1, "R1 push");
      cmem[1] = mk(51,0,1);     expw(101, 1, "R1 push");
      cmem[2] = mk(17,5,2);
      cmem[3] = mk(51,0,1);
      start();
      finish_prog(1'b1, "R5 bad key");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule